// File: doc/BRIEF.md
# Transparent Serial Link Byte Capture with Match-Start

This block takes a raw serial data link, one bit per clock-enabled cycle, and turns it into bytes written into a 64-entry by 8-bit receive FIFO. It does no framing, flag removal or CRC work. A transparent-enable control turns capture on. While it is off, the block stores nothing and forgets any partial byte.

With match mode off, bytes are packed from the point where capture was turned on. The earliest bit goes into bit 0, so the packing is LSB first.

With match mode on, the block first hunts for a programmable 8-bit character. It compares a sliding window against that character at every bit position. Once the character is found, the byte boundary is fixed at the end of the matched character, and the following bytes are stored. The matched character itself is not stored. A host reads the FIFO through a show-ahead read port and watches the count, empty, full, sticky overflow and lock outputs.

Top module: `rawlink_capture`

## Requirements
- R1: While `transpEn` is 0, no byte is written and the partial byte is discarded. After `transpEn` returns to 1, packing restarts with bit 0.
- R2: With `transpEn`=1 and `matchEn`=0, each group of 8 accepted bits forms one byte. The first bit of the group goes into bit 0 and the eighth into bit 7. The byte enters the FIFO at the clock edge that accepts the eighth bit.
- R3: With `transpEn`=1 and `matchEn`=1, nothing is written until the most recent 8 accepted bits equal `matchChar`. The newest bit is compared with bit 7 of `matchChar`, and the match may occur at any bit position.
- R4: On a match, `matchLock` goes to 1 at that edge and the matched character is not stored. The next 8 accepted bits form the first stored byte, and later bytes follow on 8-bit boundaries.
- R5: Clearing `matchEn` or `transpEn` drops `matchLock`. When match mode is next active, the block hunts again and stores nothing until a new match.
- R6: The FIFO holds 64 bytes in arrival order. `rdData` shows the oldest byte, a cycle with `rdEn`=1 on a non-empty FIFO removes it, and `fifoCount`, `fifoEmpty` and `fifoFull` track the occupancy.
- R7: A byte that completes while the count is 64 is dropped, even if a read happens in the same cycle. Such a drop sets `overflow`, which stays 1 until reset.
- R8: After reset the FIFO is empty (count 0, `fifoEmpty`=1), `overflow`=0 and `matchLock`=0.
- R9: While hunting, a match counts only after at least 8 bits have been accepted since hunting began. Bits taken before that point never complete a match.
- R10: Cycles with `bitEn`=0 do not change the window, the bit position or the lock state, whatever the value of `bitIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bitIn | input | 1 | Serial data link bit |
| bitEn | input | 1 | Qualifies `bitIn` for this cycle |
| transpEn | input | 1 | Enables transparent capture |
| matchEn | input | 1 | Enables match-start hunting |
| matchChar | input | 8 | Start character, bit 7 is the newest bit |
| rdEn | input | 1 | Pops the oldest FIFO byte |
| rdData | output | 8 | Oldest FIFO byte (show-ahead) |
| fifoCount | output | 7 | Bytes held, 0 to 64 |
| fifoEmpty | output | 1 | FIFO holds no byte |
| fifoFull | output | 1 | FIFO holds 64 bytes |
| overflow | output | 1 | Sticky: a byte was dropped |
| matchLock | output | 1 | Match found, capture aligned |

## Verification
The assertions assume that the inputs are sampled only at the rising edge and are stable around it. They also assume that `matchChar` does not change during a hunt. Without that second assumption, the check that lock rises only on an accepted bit in match mode would not pin down the cause.

The bench changes every input on the falling edge. It holds `matchChar` constant for each test and changes the mode controls only between bit groups. Pauses of varying length between bits cover the bit-enable qualification.

// File: rtl/rawlink_pkg.sv
package rawlink_pkg;
  typedef struct packed {
    logic shift;  // accept bitIn into the window
    logic push;   // window holds a complete byte to store
  } rlStrobe_t;
endpackage

// File: rtl/rawlink_fifo.sv
module rawlink_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [$clog2(DEPTH):0] count,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic wrOk, rdOk;

  assign wrOk = wrEn && (count < (AW+1)'(DEPTH));
  assign rdOk = rdEn && (count != '0);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (rdOk) rdPtr <= rdPtr + 1'b1;
      case ({wrOk, rdOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wrEn && !wrOk) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rawlink_ctrl.sv
module rawlink_ctrl #(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitEn,
  input  logic transpEn,
  input  logic matchEn,
  input  logic winHit,
  output rawlink_pkg::rlStrobe_t strobe,
  output logic locked
);
  localparam int CW = $clog2(CHAR_W + 1);

  logic [CW-1:0] fillCnt, bitCnt;
  logic hunting, active, lastBit, hit;

  assign hunting = transpEn && matchEn && !locked;
  assign active  = transpEn && (!matchEn || locked);
  assign lastBit = (bitCnt == CW'(CHAR_W - 1));
  assign hit     = hunting && bitEn && (fillCnt >= CW'(CHAR_W - 1)) && winHit;

  always_comb begin
    strobe.shift = transpEn && bitEn;
    strobe.push  = active && bitEn && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      fillCnt <= '0;
      bitCnt  <= '0;
    end else begin
      if (!transpEn || !matchEn) locked <= 1'b0;
      else if (hit)              locked <= 1'b1;

      if (!hunting) fillCnt <= '0;
      else if (bitEn && fillCnt != CW'(CHAR_W)) fillCnt <= fillCnt + 1'b1;

      if (!active)     bitCnt <= '0;
      else if (bitEn)  bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rawlink_dpath.sv
module rawlink_dpath #(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitIn,
  input  rawlink_pkg::rlStrobe_t strobe,
  input  logic [CHAR_W-1:0] matchChar,
  input  logic rdEn,
  output logic winHit,
  output logic [CHAR_W-1:0] rdData,
  output logic [$clog2(DEPTH):0] count,
  output logic overflow
);
  logic [CHAR_W-1:0] win, nextWin;

  // newest bit enters at the top, so after CHAR_W shifts the first bit sits in bit 0
  assign nextWin = {bitIn, win[CHAR_W-1:1]};
  assign winHit  = (nextWin == matchChar);

  always_ff @(posedge clk) begin
    if (!rst_n)            win <= '0;
    else if (strobe.shift) win <= nextWin;
  end

  rawlink_fifo #(.DATA_W(CHAR_W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (strobe.push),
    .wrData   (nextWin),
    .rdEn     (rdEn),
    .rdData   (rdData),
    .count    (count),
    .overflow (overflow)
  );
endmodule

// File: rtl/rawlink_capture.sv
module rawlink_capture #(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitIn,
  input  logic              bitEn,
  input  logic              transpEn,
  input  logic              matchEn,
  input  logic [CHAR_W-1:0] matchChar,
  input  logic              rdEn,
  output logic [CHAR_W-1:0] rdData,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              overflow,
  output logic              matchLock
);
  rawlink_pkg::rlStrobe_t strobe;
  logic winHit;

  rawlink_ctrl #(.CHAR_W(CHAR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .transpEn(transpEn),
    .matchEn(matchEn), .winHit(winHit), .strobe(strobe), .locked(matchLock)
  );

  rawlink_dpath #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rst_n(rst_n), .bitIn(bitIn), .strobe(strobe),
    .matchChar(matchChar), .rdEn(rdEn), .winHit(winHit),
    .rdData(rdData), .count(fifoCount), .overflow(overflow)
  );

  assign fifoEmpty = (fifoCount == '0);
  assign fifoFull  = (fifoCount == CNT_W'(DEPTH));
endmodule

// File: rtl/rawlink_capture_chk.sv
module rawlink_capture_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic bitEn,
  input logic transpEn,
  input logic matchEn,
  input logic [CNT_W-1:0] fifoCount,
  input logic fifoFull,
  input logic overflow,
  input logic matchLock
);
  p_off_no_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !transpEn |=> (fifoCount <= $past(fifoCount)));

  p_hunt_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (transpEn && matchEn && !matchLock) |=> (fifoCount <= $past(fifoCount)));

  p_lock_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matchLock) |-> $past(transpEn && matchEn && bitEn));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifoCount) - int'($past(fifoCount)) <= 1) &&
    (int'($past(fifoCount)) - int'(fifoCount) <= 1));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifoCount) <= DEPTH);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fifoFull));

  p_idle_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitEn && !matchLock) |=> !matchLock);
endmodule

bind rawlink_capture rawlink_capture_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .transpEn(transpEn),
  .matchEn(matchEn), .fifoCount(fifoCount), .fifoFull(fifoFull),
  .overflow(overflow), .matchLock(matchLock)
);

// File: tb/rawlink_capture_tb_top.sv
`timescale 1ns/1ps
module rawlink_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitIn = 1'b0, bitEn = 1'b0, transpEn = 1'b0, matchEn = 1'b0, rdEn = 1'b0;
  logic [7:0] matchChar = 8'h7E;
  logic [7:0] rdData;
  logic [6:0] fifoCount;
  logic fifoEmpty, fifoFull, overflow, matchLock;

  always #4 clk = ~clk;

  rawlink_capture dut_i (
    .clk(clk), .rst_n(rst_n), .bitIn(bitIn), .bitEn(bitEn),
    .transpEn(transpEn), .matchEn(matchEn), .matchChar(matchChar),
    .rdEn(rdEn), .rdData(rdData), .fifoCount(fifoCount),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .overflow(overflow),
    .matchLock(matchLock)
  );

  int checks = 0;
  int fails = 0;
  string curReq = "R8";
  bit doneFlag = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  byte unsigned q[$];
  int mBitCnt = 0, mFill = 0;
  bit mLock = 0, mOvf = 0;
  bit [7:0] mWin = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mBitCnt = 0; mFill = 0; mLock = 0; mOvf = 0; mWin = 0;
    end else begin
      automatic int sizeBefore = q.size();
      automatic bit doPop = rdEn && (sizeBefore > 0);
      automatic bit doPush = 0;
      automatic bit [7:0] newWin = {bitIn, mWin[7:1]};
      if (!transpEn) begin
        mLock = 0; mFill = 0; mBitCnt = 0;
      end else if (matchEn && !mLock) begin
        mBitCnt = 0;
        if (bitEn) begin
          mWin = newWin;
          if (mFill < 8) mFill++;
          if (mFill >= 8 && mWin == matchChar) begin mLock = 1; mFill = 0; end
        end
      end else begin
        if (!matchEn) mLock = 0;
        mFill = 0;
        if (bitEn) begin
          mWin = newWin;
          if (mBitCnt == 7) begin doPush = 1; mBitCnt = 0; end
          else mBitCnt++;
        end
      end
      if (doPop) void'(q.pop_front());
      if (doPush) begin
        if (sizeBefore < 64) q.push_back(mWin);
        else mOvf = 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !doneFlag) begin
      chk(curReq, "R6 fifoCount", int'(fifoCount), q.size());
      chk(curReq, "R6 fifoEmpty", int'(fifoEmpty), int'(q.size() == 0));
      chk(curReq, "R6 fifoFull", int'(fifoFull), int'(q.size() == 64));
      chk(curReq, "R7 overflow", int'(overflow), int'(mOvf));
      chk(curReq, "R4 matchLock", int'(matchLock), int'(mLock));
      if (q.size() > 0) chk(curReq, "R6 rdData", int'(rdData), int'(q[0]));
    end
  end

  task automatic sendBit(bit b, int gap);
    bitIn = b; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    for (int g = 0; g < gap; g++) begin
      bitIn = ~bitIn;  // R10: toggling while bitEn is low
      @(negedge clk);
    end
  endtask

  task automatic sendByte(bit [7:0] v, int gap);
    for (int i = 0; i < 8; i++) sendBit(v[i], (i % 3 == 1) ? gap : 0);
  endtask

  task automatic popN(int n);
    for (int i = 0; i < n; i++) begin
      rdEn = 1'b1; @(negedge clk);
    end
    rdEn = 1'b0; @(negedge clk);
  endtask

  task automatic finishRun();
    doneFlag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    curReq = "R8";
    chk("R8", "reset count", int'(fifoCount), 0);
    chk("R8", "reset empty", int'(fifoEmpty), 1);
    chk("R8", "reset overflow", int'(overflow), 0);
    chk("R8", "reset lock", int'(matchLock), 0);

    curReq = "R1";
    sendByte(8'hA5, 1); sendByte(8'h0F, 0);
    chk("R1", "no store when off", int'(fifoCount), 0);

    curReq = "R2";
    transpEn = 1'b1; @(negedge clk);
    sendByte(8'h3C, 0); sendByte(8'h81, 2);
    chk("R2", "two bytes", int'(fifoCount), 2);
    chk("R2", "LSB-first byte", int'(rdData), 8'h3C);
    popN(1);
    chk("R6", "order", int'(rdData), 8'h81);
    popN(1);

    curReq = "R1";
    for (int i = 0; i < 5; i++) sendBit(1'b1, 0);
    transpEn = 1'b0; @(negedge clk);
    transpEn = 1'b1; @(negedge clk);
    sendByte(8'h5A, 1);
    chk("R1", "partial discarded count", int'(fifoCount), 1);
    chk("R1", "realigned byte", int'(rdData), 8'h5A);
    popN(1);

    curReq = "R3";
    matchEn = 1'b1; @(negedge clk);
    sendBit(1'b1, 0); sendBit(1'b0, 1); sendBit(1'b1, 0);
    sendByte(8'h00, 0); sendByte(8'hC3, 1);
    chk("R3", "nothing stored while hunting", int'(fifoCount), 0);
    sendByte(8'h7E, 2);
    chk("R4", "locked after match", int'(matchLock), 1);
    chk("R4", "match char not stored", int'(fifoCount), 0);
    sendByte(8'h12, 1); sendByte(8'h34, 0);
    chk("R4", "first stored byte", int'(rdData), 8'h12);
    chk("R4", "aligned count", int'(fifoCount), 2);
    popN(2);

    curReq = "R5";
    matchEn = 1'b0; @(negedge clk);
    matchEn = 1'b1; @(negedge clk);
    chk("R5", "lock dropped", int'(matchLock), 0);
    sendByte(8'h55, 0); sendByte(8'h55, 1);
    chk("R5", "hunting again stores nothing", int'(fifoCount), 0);

    curReq = "R9";
    matchEn = 1'b0; transpEn = 1'b0; @(negedge clk);
    transpEn = 1'b1; @(negedge clk);
    sendBit(1'b0, 0); sendBit(1'b1, 0); sendBit(1'b1, 0); sendBit(1'b1, 0);
    matchEn = 1'b1; @(negedge clk);
    sendBit(1'b1, 0); sendBit(1'b1, 0); sendBit(1'b1, 1); sendBit(1'b0, 0);
    chk("R9", "stale bits give no lock", int'(matchLock), 0);
    sendByte(8'h7E, 0);
    chk("R9", "full window locks", int'(matchLock), 1);
    sendByte(8'h99, 0);
    chk("R9", "byte after lock", int'(rdData), 8'h99);
    popN(1);

    curReq = "R10";
    sendBit(1'b1, 6); sendBit(1'b0, 6);
    chk("R10", "idle cycles keep lock", int'(matchLock), 1);
    for (int i = 2; i < 8; i++) sendBit(1'b0, 0);
    chk("R10", "gapped byte stored", int'(rdData), 8'h01);
    popN(1);

    curReq = "R7";
    matchEn = 1'b0; transpEn = 1'b0; @(negedge clk);
    transpEn = 1'b1; @(negedge clk);
    for (int i = 0; i < 66; i++) sendByte(8'(i + 1), 0);
    chk("R7", "count at full", int'(fifoCount), 64);
    chk("R7", "full flag", int'(fifoFull), 1);
    chk("R7", "overflow set", int'(overflow), 1);
    chk("R7", "oldest kept", int'(rdData), 8'h01);
    popN(63);
    chk("R7", "last kept byte", int'(rdData), 64);
    popN(1);
    chk("R7", "overflow sticky", int'(overflow), 1);
    chk("R6", "empty after drain", int'(fifoEmpty), 1);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule